// File: doc/BRIEF.md
# Configuration Load Sequencer

This block walks a programmable-logic configuration port through one complete load. A single-cycle start request begins the run. The block latches a partial-load flag and a byte length with the request. A full load first isolates the programmable logic and pulses an active-low program strobe. It then waits for the init status to fall and rise again. A partial load skips all of that.

Both kinds of load then go through the same steps. The block samples the sticky interrupt flags and clears them all. It aborts on a fatal flag, and flushes the receive FIFO first if that flag is an overflow. It checks the command queue. It clears a non-zero completed-transfer count. It asks an external data mover for the transfer, giving the length in 32-bit words. Last, it waits for transfer-done and then configuration-done. Each wait has a timeout counted in clock cycles.

The result stays on `done_o` or `fail_o`, with a reason code, until the next start request. The data mover and the register bus sit outside this block.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset the strobe `prog_n_o` is 1, and `isolate_o`, `busy_o`, `done_o`, `fail_o` and `xfer_req_o` are 0.
- R2: A full load (`partial_i`=0) does the following, in order:
  - raises `isolate_o` while the strobe is held high;
  - drives the strobe low and waits for `init_stat_i`=0;
  - drives the strobe high and waits for `init_stat_i`=1;
  - after configuration-done, drops `isolate_o` in the same cycle that `done_o` rises.
- R3: A partial load (`partial_i`=1) never drives the strobe low and never raises `isolate_o`.
- R4: Timeouts, with each wait restarting its count when it is entered:
  - Each init wait and the configuration-done wait give up after SHORT_TMO cycles.
  - The transfer-done wait gives up exactly LONG_TMO cycles after `xfer_req_o` rises.
  - The fail codes are 1 (init low), 2 (init high), 6 (transfer) and 7 (config).
- R5: Flag sampling: before the queue check, the block samples `irq_flags_i` and pulses `flag_clr_o` with an all-ones mask, exactly once. If the sample has any bit of mask 0x00740040 set, the load fails with code 3. Other set flags, such as bit 11, do not stop the load.
- R6: If the sampled fatal set includes bit 18 (receive overflow), one `rx_flush_o` pulse follows, and then a second all-ones clear, before the load fails with code 3.
- R7: Command queue check:
  - If `cmdq_full_i`=1, the load fails with code 4.
  - If the queue is not empty and live flag bit 13 is 0, the load fails with code 5.
  - If the queue is not empty and bit 13 is 1, the block clears bit 13 (mask 0x00002000) and goes on.
- R8: Every load pulses `loopback_clr_o` once. A load that reaches the transfer step with `done_cnt_i` non-zero pulses `done_cnt_clr_o` once.
- R9: `xfer_req_o` is a single-cycle pulse, issued once per load, with `xfer_words_o` equal to the latched byte length shifted right by 2. When flag bit 13 is seen, the block clears it with one pulse of mask 0x00002000. It then waits for flag bit 2 and finishes with `done_o`.
- R10: `done_o` and `fail_o` are never both high. Each holds until the next start request. A failure leaves `isolate_o` as it was. The code on `fail_code_o` is 0 after a success.
- R11: A start request while `busy_o`=1 has no effect: no second transfer, and the first request's length and mode are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load request, taken only when idle |
| partial_i | input | 1 | 1 selects a partial load, latched with start |
| xfer_bytes_i | input | LEN_W | Load length in bytes, latched with start |
| init_stat_i | input | 1 | Init status from the configuration port |
| cmdq_full_i | input | 1 | Data mover command queue full |
| cmdq_empty_i | input | 1 | Data mover command queue empty |
| done_cnt_i | input | CNT_W | Completed-transfer count |
| irq_flags_i | input | 32 | Sticky interrupt flags (bit 2 config done, bit 13 transfer done, bit 18 receive overflow) |
| prog_n_o | output | 1 | Active-low program strobe |
| isolate_o | output | 1 | Logic-to-system isolation enable |
| loopback_clr_o | output | 1 | Pulse: clear the loopback control |
| flag_clr_o | output | 1 | Pulse: write-one-to-clear of flags |
| flag_clr_mask_o | output | 32 | Bits to clear with `flag_clr_o` |
| rx_flush_o | output | 1 | Pulse: flush receive FIFO |
| done_cnt_clr_o | output | 1 | Pulse: clear completed-transfer count |
| xfer_req_o | output | 1 | Pulse: start the data mover |
| xfer_words_o | output | LEN_W-2 | Transfer length in 32-bit words |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished successfully (held) |
| fail_o | output | 1 | Load aborted (held) |
| fail_code_o | output | 3 | Abort reason, 0 when none |

## Verification
The bound checker watches a set of properties on every cycle:
- `done_o` and `fail_o` are exclusive, and each holds until a start request;
- the transfer request is a single-cycle pulse, and only while busy;
- the strobe falls only while isolation is active;
- isolation is released only together with `done_o`;
- a flush is always followed by a full flag clear.

The other rules depend on the order and number of events across a whole load, so only the bench's scenarios can show them. These are the fail-code priority, the clear and flush counts, the word count, the exact transfer timeout, and start requests being ignored. The bench sweeps every fault scenario in both full and partial mode against a behavioural port model.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  localparam int FLAG_W = 32;
  localparam int XD_BIT  = 13;
  localparam int CD_BIT  = 2;
  localparam int OVF_BIT = 18;
  localparam logic [FLAG_W-1:0] FATAL_MASK = 32'h0074_0040;
  localparam logic [FLAG_W-1:0] XD_MASK    = 32'h0000_2000;

  typedef enum logic [3:0] {
    S_IDLE, S_LPBK, S_STRB, S_WAIT_LO, S_WAIT_HI, S_CAPT, S_EVAL,
    S_FLUSH, S_RECLR, S_QCHK, S_CNT, S_XFER, S_WAIT_XD, S_WAIT_CD
  } seq_state_e;

  typedef enum logic [2:0] {
    F_NONE, F_INIT_LO, F_INIT_HI, F_FATAL, F_QFULL, F_QERR, F_XD_TMO, F_CD_TMO
  } fail_e;

endpackage

// File: rtl/cfg_tmo_ctr.sv
module cfg_tmo_ctr #(
  parameter int SHORT_TMO = 1000,
  parameter int LONG_TMO  = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic sel_long_i,
  output logic expired_o
);
  localparam int MAXV = (LONG_TMO > SHORT_TMO) ? LONG_TMO : SHORT_TMO;
  localparam int W = $clog2(MAXV + 1);
  localparam logic [W-1:0] SHORT_LAST = W'(SHORT_TMO - 1);
  localparam logic [W-1:0] LONG_LAST  = W'(LONG_TMO - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt_q <= '0;
    else if (!expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = sel_long_i ? (cnt_q >= LONG_LAST) : (cnt_q >= SHORT_LAST);
endmodule

// File: rtl/cfg_flag_eval.sv
module cfg_flag_eval
  import cfg_load_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              fatal_o,
  output logic              ovf_o
);
  logic fatal_q, ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fatal_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (cap_en_i) begin
      fatal_q <= |(flags_i & FATAL_MASK);
      ovf_q   <= flags_i[OVF_BIT];
    end
  end

  assign fatal_o = fatal_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
  import cfg_load_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              partial_i,
  input  logic [LEN_W-1:0]  bytes_i,
  input  logic              init_i,
  input  logic              qfull_i,
  input  logic              qempty_i,
  input  logic              dcnt_nz_i,
  input  logic              xd_flag_i,
  input  logic              cd_flag_i,
  input  logic              fatal_i,
  input  logic              ovf_i,
  input  logic              expired_i,
  output logic              restart_o,
  output logic              sel_long_o,
  output logic              cap_en_o,
  output logic              prog_n_o,
  output logic              iso_o,
  output logic              loop_clr_o,
  output logic              clr_o,
  output logic [FLAG_W-1:0] clr_mask_o,
  output logic              flush_o,
  output logic              cnt_clr_o,
  output logic              xreq_o,
  output logic [LEN_W-3:0]  words_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [2:0]        code_o
);
  localparam int WRD_W = LEN_W - 2;

  seq_state_e state_q, state_d;
  logic             part_q;
  logic [WRD_W-1:0] len_q;
  logic             prog_d;
  logic             go_fail;
  fail_e            fcode;
  logic             a_clr_all, a_clr_xd, a_loop, a_flush, a_cnt, a_xreq, a_done, a_iso;

  always_comb begin
    state_d   = state_q;
    prog_d    = prog_n_o;
    go_fail   = 1'b0;
    fcode     = F_NONE;
    a_clr_all = 1'b0;
    a_clr_xd  = 1'b0;
    a_loop    = 1'b0;
    a_flush   = 1'b0;
    a_cnt     = 1'b0;
    a_xreq    = 1'b0;
    a_done    = 1'b0;
    a_iso     = 1'b0;
    cap_en_o  = 1'b0;
    sel_long_o = 1'b0;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = S_LPBK;
      S_LPBK: begin
        a_loop = 1'b1;
        prog_d = 1'b1;
        if (part_q) state_d = S_CAPT;
        else begin
          a_iso   = 1'b1;
          state_d = S_STRB;
        end
      end
      S_STRB: begin
        prog_d  = 1'b0;
        state_d = S_WAIT_LO;
      end
      S_WAIT_LO: begin
        if (!init_i) begin
          prog_d  = 1'b1;
          state_d = S_WAIT_HI;
        end else if (expired_i) begin
          go_fail = 1'b1;
          fcode   = F_INIT_LO;
        end
      end
      S_WAIT_HI: begin
        if (init_i) state_d = S_CAPT;
        else if (expired_i) begin
          go_fail = 1'b1;
          fcode   = F_INIT_HI;
        end
      end
      S_CAPT: begin
        cap_en_o  = 1'b1;
        a_clr_all = 1'b1;
        state_d   = S_EVAL;
      end
      S_EVAL: begin
        if (fatal_i) begin
          if (ovf_i) state_d = S_FLUSH;
          else begin
            go_fail = 1'b1;
            fcode   = F_FATAL;
          end
        end else begin
          state_d = S_QCHK;
        end
      end
      S_FLUSH: begin
        a_flush = 1'b1;
        state_d = S_RECLR;
      end
      S_RECLR: begin
        a_clr_all = 1'b1;
        go_fail   = 1'b1;
        fcode     = F_FATAL;
      end
      S_QCHK: begin
        if (qfull_i) begin
          go_fail = 1'b1;
          fcode   = F_QFULL;
        end else if (!qempty_i && !xd_flag_i) begin
          go_fail = 1'b1;
          fcode   = F_QERR;
        end else begin
          a_clr_xd = !qempty_i;
          state_d  = S_CNT;
        end
      end
      S_CNT: begin
        a_cnt   = dcnt_nz_i;
        state_d = S_XFER;
      end
      S_XFER: begin
        a_xreq  = 1'b1;
        state_d = S_WAIT_XD;
      end
      S_WAIT_XD: begin
        sel_long_o = 1'b1;
        if (xd_flag_i) begin
          a_clr_xd = 1'b1;
          state_d  = S_WAIT_CD;
        end else if (expired_i) begin
          go_fail = 1'b1;
          fcode   = F_XD_TMO;
        end
      end
      S_WAIT_CD: begin
        if (cd_flag_i) begin
          a_done  = 1'b1;
          state_d = S_IDLE;
        end else if (expired_i) begin
          go_fail = 1'b1;
          fcode   = F_CD_TMO;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (go_fail) begin
      state_d = S_IDLE;
      prog_d  = 1'b1;
    end
  end

  assign restart_o = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      part_q     <= 1'b0;
      len_q      <= '0;
      prog_n_o   <= 1'b1;
      iso_o      <= 1'b0;
      loop_clr_o <= 1'b0;
      clr_o      <= 1'b0;
      clr_mask_o <= '0;
      flush_o    <= 1'b0;
      cnt_clr_o  <= 1'b0;
      xreq_o     <= 1'b0;
      words_o    <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
      code_o     <= 3'd0;
    end else begin
      state_q    <= state_d;
      prog_n_o   <= prog_d;
      loop_clr_o <= a_loop;
      flush_o    <= a_flush;
      cnt_clr_o  <= a_cnt;
      xreq_o     <= a_xreq;
      clr_o      <= a_clr_all | a_clr_xd;
      clr_mask_o <= a_clr_all ? {FLAG_W{1'b1}} : (a_clr_xd ? XD_MASK : '0);
      if (state_q == S_IDLE && start_i) begin
        part_q <= partial_i;
        len_q  <= bytes_i[LEN_W-1:2];
        busy_o <= 1'b1;
        done_o <= 1'b0;
        fail_o <= 1'b0;
        code_o <= 3'd0;
      end
      if (a_iso)  iso_o   <= 1'b1;
      if (a_xreq) words_o <= len_q;
      if (a_done) begin
        done_o <= 1'b1;
        busy_o <= 1'b0;
        if (!part_q) iso_o <= 1'b0;
      end
      if (go_fail) begin
        fail_o <= 1'b1;
        busy_o <= 1'b0;
        code_o <= fcode;
      end
    end
  end
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int LEN_W     = 32,
  parameter int CNT_W     = 2,
  parameter int SHORT_TMO = 1000,
  parameter int LONG_TMO  = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              partial_i,
  input  logic [LEN_W-1:0]  xfer_bytes_i,
  input  logic              init_stat_i,
  input  logic              cmdq_full_i,
  input  logic              cmdq_empty_i,
  input  logic [CNT_W-1:0]  done_cnt_i,
  input  logic [FLAG_W-1:0] irq_flags_i,
  output logic              prog_n_o,
  output logic              isolate_o,
  output logic              loopback_clr_o,
  output logic              flag_clr_o,
  output logic [FLAG_W-1:0] flag_clr_mask_o,
  output logic              rx_flush_o,
  output logic              done_cnt_clr_o,
  output logic              xfer_req_o,
  output logic [LEN_W-3:0]  xfer_words_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [2:0]        fail_code_o
);
  logic restart, sel_long, expired, cap_en, fatal, ovf;

  cfg_tmo_ctr #(.SHORT_TMO(SHORT_TMO), .LONG_TMO(LONG_TMO)) u_tmo (
    .clk(clk), .rst(rst), .restart_i(restart), .sel_long_i(sel_long), .expired_o(expired)
  );

  cfg_flag_eval u_flags (
    .clk(clk), .rst(rst), .cap_en_i(cap_en), .flags_i(irq_flags_i),
    .fatal_o(fatal), .ovf_o(ovf)
  );

  cfg_load_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .partial_i(partial_i), .bytes_i(xfer_bytes_i),
    .init_i(init_stat_i), .qfull_i(cmdq_full_i), .qempty_i(cmdq_empty_i),
    .dcnt_nz_i(|done_cnt_i), .xd_flag_i(irq_flags_i[XD_BIT]), .cd_flag_i(irq_flags_i[CD_BIT]),
    .fatal_i(fatal), .ovf_i(ovf), .expired_i(expired),
    .restart_o(restart), .sel_long_o(sel_long), .cap_en_o(cap_en),
    .prog_n_o(prog_n_o), .iso_o(isolate_o), .loop_clr_o(loopback_clr_o),
    .clr_o(flag_clr_o), .clr_mask_o(flag_clr_mask_o), .flush_o(rx_flush_o),
    .cnt_clr_o(done_cnt_clr_o), .xreq_o(xfer_req_o), .words_o(xfer_words_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .code_o(fail_code_o)
  );
endmodule

// File: rtl/cfg_load_seq_chk.sv
module cfg_load_seq_chk #(
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          prog_n_o,
  input logic          isolate_o,
  input logic          flag_clr_o,
  input logic [FW-1:0] flag_clr_mask_o,
  input logic          rx_flush_o,
  input logic          xfer_req_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o
);
  p_excl_r10: assert property (@(posedge clk) disable iff (rst) !(done_o && fail_o));
  p_hold_done_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);
  p_hold_fail_r10: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !start_i) |=> fail_o);
  p_xreq_busy_r9: assert property (@(posedge clk) disable iff (rst) xfer_req_o |-> busy_o);
  p_xreq_pulse_r9: assert property (@(posedge clk) disable iff (rst) xfer_req_o |=> !xfer_req_o);
  p_strobe_iso_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_n_o) |-> isolate_o);
  p_iso_release_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(isolate_o) |-> done_o);
  p_flush_reclr_r6: assert property (@(posedge clk) disable iff (rst)
    rx_flush_o |=> (flag_clr_o && (&flag_clr_mask_o)));
endmodule

bind cfg_load_seq cfg_load_seq_chk #(.FW(32)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .prog_n_o(prog_n_o), .isolate_o(isolate_o),
  .flag_clr_o(flag_clr_o), .flag_clr_mask_o(flag_clr_mask_o), .rx_flush_o(rx_flush_o),
  .xfer_req_o(xfer_req_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/tb_cfg_load_seq.sv
`timescale 1ns/1ps
module tb_cfg_load_seq;
  localparam int LEN_W = 32;
  localparam int SHORT_TMO = 24;
  localparam int LONG_TMO  = 80;
  localparam logic [31:0] FATAL = 32'h0074_0040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, partial_i = 1'b0;
  logic [31:0] xfer_bytes_i = '0;
  logic init_stat_i = 1'b1, cmdq_full_i = 1'b0, cmdq_empty_i = 1'b1;
  logic [1:0] done_cnt_i = '0;
  logic [31:0] irq_flags_i = '0;
  logic prog_n_o, isolate_o, loopback_clr_o, flag_clr_o, rx_flush_o, done_cnt_clr_o, xfer_req_o;
  logic [31:0] flag_clr_mask_o;
  logic [29:0] xfer_words_o;
  logic busy_o, done_o, fail_o;
  logic [2:0] fail_code_o;

  always #2 clk = ~clk;

  cfg_load_seq #(.LEN_W(LEN_W), .CNT_W(2), .SHORT_TMO(SHORT_TMO), .LONG_TMO(LONG_TMO)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .partial_i(partial_i), .xfer_bytes_i(xfer_bytes_i),
    .init_stat_i(init_stat_i), .cmdq_full_i(cmdq_full_i), .cmdq_empty_i(cmdq_empty_i),
    .done_cnt_i(done_cnt_i), .irq_flags_i(irq_flags_i), .prog_n_o(prog_n_o),
    .isolate_o(isolate_o), .loopback_clr_o(loopback_clr_o), .flag_clr_o(flag_clr_o),
    .flag_clr_mask_o(flag_clr_mask_o), .rx_flush_o(rx_flush_o), .done_cnt_clr_o(done_cnt_clr_o),
    .xfer_req_o(xfer_req_o), .xfer_words_o(xfer_words_o), .busy_o(busy_o), .done_o(done_o),
    .fail_o(fail_o), .fail_code_o(fail_code_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // port model controls and observation counters
  bit fall_en, rise_en, xd_en, cd_en, re13, re_used;
  int lo_t, hi_t, xd_t, cd_t, cyc, xreq_cyc, fail_cyc;
  bit xd_act, cd_act, prog_prev, fail_prev, iso_seen;
  int n_clr_all, n_clr_xd, n_flush, n_loop, n_cnt, n_xreq, n_fall;
  logic [29:0] words_seen;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (flag_clr_o) begin
        irq_flags_i = irq_flags_i & ~flag_clr_mask_o;
        if (&flag_clr_mask_o) begin
          n_clr_all++;
          if (re13 && !re_used) begin irq_flags_i[13] = 1'b1; re_used = 1; end
        end
        if (flag_clr_mask_o == 32'h0000_2000) n_clr_xd++;
      end
      if (rx_flush_o) n_flush++;
      if (loopback_clr_o) n_loop++;
      if (done_cnt_clr_o) begin n_cnt++; done_cnt_i = 2'd0; end
      if (isolate_o) iso_seen = 1;
      if (prog_prev && !prog_n_o) n_fall++;
      prog_prev = prog_n_o;
      if (!prog_n_o) begin
        hi_t = 0;
        if (fall_en) begin lo_t++; if (lo_t >= 5) init_stat_i = 1'b0; end
      end else begin
        lo_t = 0;
        if (!init_stat_i && rise_en) begin hi_t++; if (hi_t >= 7) init_stat_i = 1'b1; end
      end
      if (xfer_req_o) begin
        n_xreq++; words_seen = xfer_words_o; xreq_cyc = cyc; xd_act = 1; xd_t = 0;
      end else if (xd_act) begin
        xd_t++;
        if (xd_en && xd_t >= 30) begin irq_flags_i[13] = 1'b1; xd_act = 0; cd_act = 1; cd_t = 0; end
      end else if (cd_act) begin
        cd_t++;
        if (cd_en && cd_t >= 10) begin irq_flags_i[2] = 1'b1; cd_act = 0; end
      end
      if (fail_o && !fail_prev) fail_cyc = cyc;
      fail_prev = fail_o;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(bit p, int s);
    logic [31:0] pre = '0;
    bit qf = 0, qe = 1, fl = 1, ri = 1, xd = 1, cd = 1, re = 0;
    int dc = 0, code, waitc;
    logic [31:0] bytes = 32'(64 + 20*s + (s % 4));
    bit fat, reach_capt, reach_cnt;
    case (s)
      1: fl = 0;
      2: ri = 0;
      3: pre = 32'h0000_0040;
      4: pre = 32'h0004_0000;
      5: pre = 32'h0040_0000;
      6: qf = 1;
      7: qe = 0;
      8: begin qe = 0; re = 1; end
      9: dc = 2;
      10: xd = 0;
      11: cd = 0;
      12: pre = 32'h0000_2800;
      default: ;
    endcase
    fat = |(pre & FATAL);
    if (!p && !fl) code = 1;
    else if (!p && !ri) code = 2;
    else if (fat) code = 3;
    else if (qf) code = 4;
    else if (!qe && !re) code = 5;
    else if (!xd) code = 6;
    else if (!cd) code = 7;
    else code = 0;
    reach_capt = (code != 1) && (code != 2);
    reach_cnt  = (code == 0) || (code == 6) || (code == 7);

    @(negedge clk); #1;
    irq_flags_i = pre; cmdq_full_i = qf; cmdq_empty_i = qe; done_cnt_i = 2'(dc);
    fall_en = fl; rise_en = ri; xd_en = xd; cd_en = cd; re13 = re; re_used = 0;
    init_stat_i = 1'b1; xd_act = 0; cd_act = 0; iso_seen = 0;
    n_clr_all = 0; n_clr_xd = 0; n_flush = 0; n_loop = 0; n_cnt = 0; n_xreq = 0; n_fall = 0;
    words_seen = '0; xreq_cyc = 0; fail_cyc = 0;
    start_i = 1'b1; partial_i = p; xfer_bytes_i = bytes;
    @(negedge clk); #1;
    start_i = 1'b0;
    @(negedge clk); #1;
    // R11: second request while busy, other mode and length
    check("R11 busy during load", busy_o, 1);
    start_i = 1'b1; partial_i = !p; xfer_bytes_i = 32'd4000;
    @(negedge clk); #1;
    start_i = 1'b0;
    waitc = 0;
    while (busy_o && waitc < 2000) begin @(negedge clk); #1; waitc++; end
    check("R4 load terminates", busy_o, 0);
    check("R4 R5 R7 fail code", fail_code_o, code);
    check("R9 done", done_o, code == 0);
    check("R10 fail", fail_o, code != 0);
    check("R8 loopback clear once", n_loop, 1);
    check("R2 R3 strobe falls", n_fall, p ? 0 : 1);
    check("R2 R3 isolation seen", iso_seen, !p);
    check("R2 R10 isolation final", isolate_o, (!p && code != 0) ? 1 : 0);
    check("R5 R6 full clears", n_clr_all, reach_capt ? (1 + ((fat && pre[18]) ? 1 : 0)) : 0);
    check("R6 flush", n_flush, (reach_capt && fat && pre[18]) ? 1 : 0);
    check("R8 count clear", n_cnt, (reach_cnt && dc != 0) ? 1 : 0);
    check("R9 R11 single transfer", n_xreq, reach_cnt ? 1 : 0);
    if (reach_cnt) check("R9 R11 word count", int'(words_seen), int'(bytes >> 2));
    check("R7 R9 done-flag clears", n_clr_xd,
          ((reach_cnt && !qe) ? 1 : 0) + ((code == 0 || code == 7) ? 1 : 0));
    if (code == 6) check("R4 transfer timeout cycles", fail_cyc - xreq_cyc, LONG_TMO);
    if (code == 0) check("R10 success code zero", fail_code_o, 0);
    repeat (6) @(negedge clk);
    #1;
    check("R10 result held", {done_o, fail_o}, {code == 0, code != 0});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    check("R1 strobe", prog_n_o, 1);
    check("R1 isolate", isolate_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 fail", fail_o, 0);
    check("R1 xfer req", xfer_req_o, 0);
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 13; s++)
        run(p[0], s);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule